// File: doc/BRIEF.md
# Sequential-Access Input Gamma Table

This block stores a 256-entry colour correction table with three 12-bit components per entry (red, green, blue), each component an unsigned fraction with twelve fractional bits. A host loads it through a narrow port: it first writes a start index, then streams component words through one shared data input. Each accepted word lands in the current channel of the current entry. The channel pointer moves from red to green to blue. After blue the pointer returns to red and the index moves on by one.

A three-bit write-enable mask selects which channels store data. A channel whose bit is clear still uses up its slot in the rotation, so the host can rewrite one colour of a range of entries without touching the others. A memory power input gates host data writes: while it is low the table and the pointers stay as they are. On the pixel side, three independent 8-bit codes are looked up in parallel. The three 12-bit results appear one clock later.

Top module: `gamma_seq_lut`

## Requirements
- R1: While reset is asserted, the current index reads 0, the channel pointer reads 0 (red) and all three lookup outputs read 0.
- R2: An index write loads the index and returns the channel pointer to red. This happens even in the middle of an entry. A data write in the same cycle is dropped and stores nothing.
- R3: With power on, each data write advances the channel pointer through the codes 0 (red), 1 (green) and 2 (blue). The index stays the same until the blue slot is written.
- R4: A data write in the blue slot returns the pointer to red and increments the index by one, wrapping from 255 to 0.
- R5: Mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A write to a slot whose mask bit is clear leaves the stored component unchanged but still advances the pointer.
- R6: While the power input is low, data writes store nothing and leave the index and the channel pointer unchanged.
- R7: The stored components of the entries addressed by the pixel codes appear on the lookup outputs on the clock edge after the codes are presented.
- R8: Each channel is looked up with its own code: the red output uses the red code, the green output the green code and the blue output the blue code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx_wr | input | 1 | Load the index from host_idx |
| host_idx | input | 8 | New table index |
| host_data_wr | input | 1 | Write one component word |
| host_data | input | 12 | Component word, u0.12 |
| host_mask | input | 3 | Channel write enables (bit0 R, bit1 G, bit2 B) |
| lut_pwr_on | input | 1 | Table memory powered; host data writes allowed |
| host_cur_idx | output | 8 | Current table index |
| host_cur_chan | output | 2 | Current channel slot (0 R, 1 G, 2 B) |
| pix_r | input | 8 | Red code to look up |
| pix_g | input | 8 | Green code to look up |
| pix_b | input | 8 | Blue code to look up |
| lut_r | output | 12 | Red result |
| lut_g | output | 12 | Green result |
| lut_b | output | 12 | Blue result |

## Verification
A wrong channel pointer or index shows up right away on the exposed pointer outputs. It also shows as a whole run of misplaced components that a full-table sweep of all 256 codes exposes one cycle after each lookup. A mask or power fault corrupts exactly the entries written under it. Looking those entries up again, together with their unmasked neighbours, brings the fault out within a few cycles. Index writes that collide with data writes are checked both on the pointer outputs and on the stored entry.

// File: rtl/gsl_pkg.sv
package gsl_pkg;
  localparam int NCH = 3;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  // next slot in the red -> green -> blue rotation
  function automatic chan_e chan_after(chan_e c);
    case (c)
      CH_RED:   return CH_GREEN;
      CH_GREEN: return CH_BLUE;
      default:  return CH_RED;
    endcase
  endfunction

  // true when this slot closes an entry
  function automatic logic entry_done(chan_e c);
    return c == CH_BLUE;
  endfunction
endpackage

// File: rtl/gsl_seq_ctrl.sv
module gsl_seq_ctrl
  import gsl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             data_wr,
  input  logic             pwr_on,
  input  logic [NCH-1:0]   mask,
  output logic [IDX_W-1:0] cur_idx,
  output chan_e            cur_chan,
  output logic [NCH-1:0]   ch_wr
);
  logic accept;

  // an index write wins over a data write in the same cycle
  assign accept = data_wr && pwr_on && !idx_wr;

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign ch_wr[g] = accept && (cur_chan == chan_e'(g)) && mask[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_chan <= CH_RED;
    end else if (idx_wr) begin
      cur_idx  <= idx_val;
      cur_chan <= CH_RED;
    end else if (accept) begin
      cur_chan <= chan_after(cur_chan);
      if (entry_done(cur_chan)) cur_idx <= cur_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/gsl_chan_ram.sv
module gsl_chan_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/gamma_seq_lut.sv
module gamma_seq_lut
  import gsl_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_idx_wr,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic              host_data_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [2:0]        host_mask,
  input  logic              lut_pwr_on,
  output logic [IDX_W-1:0]  host_cur_idx,
  output logic [1:0]        host_cur_chan,
  input  logic [IDX_W-1:0]  pix_r,
  input  logic [IDX_W-1:0]  pix_g,
  input  logic [IDX_W-1:0]  pix_b,
  output logic [DATA_W-1:0] lut_r,
  output logic [DATA_W-1:0] lut_g,
  output logic [DATA_W-1:0] lut_b
);
  chan_e             cur_chan;
  logic [NCH-1:0]    ch_wr_en;
  logic [IDX_W-1:0]  code [NCH];
  logic [DATA_W-1:0] res  [NCH];

  gsl_seq_ctrl #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (host_idx_wr),
    .idx_val  (host_idx),
    .data_wr  (host_data_wr),
    .pwr_on   (lut_pwr_on),
    .mask     (host_mask),
    .cur_idx  (host_cur_idx),
    .cur_chan (cur_chan),
    .ch_wr    (ch_wr_en)
  );

  assign host_cur_chan = cur_chan;

  assign code[0] = pix_r;
  assign code[1] = pix_g;
  assign code[2] = pix_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gsl_chan_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ch_wr_en[c]),
      .waddr (host_cur_idx),
      .wdata (host_data),
      .raddr (code[c]),
      .rdata (res[c])
    );
  end

  assign lut_r = res[0];
  assign lut_g = res[1];
  assign lut_b = res[2];
endmodule

// File: rtl/gamma_seq_lut_chk.sv
module gamma_seq_lut_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_wr,
  input logic [IDX_W-1:0] idx_val,
  input logic             data_wr,
  input logic             pwr_on,
  input logic [2:0]       mask,
  input logic [IDX_W-1:0] cur_idx,
  input logic [1:0]       cur_chan,
  input logic [2:0]       wr_ch
);
  logic taken;
  assign taken = data_wr && pwr_on && !idx_wr;

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cur_idx == $past(idx_val)) && (cur_chan == 2'd0));

  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cur_chan != 2'd2) |=>
      (cur_chan == $past(cur_chan) + 2'd1) && (cur_idx == $past(cur_idx)));

  p_entry_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cur_chan == 2'd2) |=>
      (cur_chan == 2'd0) && (cur_idx == $past(cur_idx) + IDX_W'(1)));

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_ch) && ((wr_ch & ~mask) == 3'b000));

  p_power_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (wr_ch == 3'b000));

  p_power_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && !idx_wr) |=> $stable(cur_idx) && $stable(cur_chan));
endmodule

bind gamma_seq_lut gamma_seq_lut_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idx_wr   (host_idx_wr),
  .idx_val  (host_idx),
  .data_wr  (host_data_wr),
  .pwr_on   (lut_pwr_on),
  .mask     (host_mask),
  .cur_idx  (host_cur_idx),
  .cur_chan (host_cur_chan),
  .wr_ch    (ch_wr_en)
);

// File: tb/gamma_seq_lut_bench.sv
module gamma_seq_lut_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_idx_wr = 0;
  logic [7:0]  host_idx = 0;
  logic        host_data_wr = 0;
  logic [11:0] host_data = 0;
  logic [2:0]  host_mask = 3'b111;
  logic        lut_pwr_on = 0;
  logic [7:0]  host_cur_idx;
  logic [1:0]  host_cur_chan;
  logic [7:0]  pix_r = 0, pix_g = 0, pix_b = 0;
  logic [11:0] lut_r, lut_g, lut_b;

  int n_chk = 0, n_fail = 0;
  logic [11:0] model [3][256];
  int m_idx = 0, m_ch = 0;

  always #4 clk = ~clk;

  gamma_seq_lut u_gamma_seq_lut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(int i, int c, int salt);
    return 12'(i * 37 + c * 1111 + salt * 211 + 5);
  endfunction

  task automatic set_idx(int v);
    @(negedge clk); host_idx_wr = 1; host_idx = 8'(v);
    @(negedge clk); host_idx_wr = 0;
    m_idx = v; m_ch = 0;
  endtask

  task automatic wr(logic [11:0] d);
    @(negedge clk); host_data_wr = 1; host_data = d;
    @(negedge clk); host_data_wr = 0;
    if (lut_pwr_on) begin
      if (host_mask[m_ch]) model[m_ch][m_idx] = d;
      if (m_ch == 2) begin m_ch = 0; m_idx = (m_idx + 1) % 256; end
      else m_ch++;
    end
  endtask

  task automatic look(string req, int r, int g, int b);
    @(negedge clk); pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    @(negedge clk);
    chk(req, lut_r, model[0][r]);
    chk(req, lut_g, model[1][g]);
    chk(req, lut_b, model[2][b]);
  endtask

  task automatic pos(string req);
    chk(req, host_cur_idx, m_idx);
    chk(req, host_cur_chan, m_ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 idx", host_cur_idx, 0);
    chk("R1 chan", host_cur_chan, 0);
    chk("R1 r", lut_r, 0); chk("R1 g", lut_g, 0); chk("R1 b", lut_b, 0);
    rst_n = 1; lut_pwr_on = 1; host_mask = 3'b111;

    // full fill, R3 rotation checked on the first entry
    set_idx(0);
    wr(pat(0, 0, 0)); pos("R3 after red");
    wr(pat(0, 1, 0)); pos("R3 after green");
    chk("R3 chan blue", host_cur_chan, 2);
    wr(pat(0, 2, 0)); pos("R4 after blue");
    chk("R4 idx step", host_cur_idx, 1);
    for (int i = 1; i < 256; i++)
      for (int c = 0; c < 3; c++) wr(pat(i, c, 0));
    chk("R4 wrap idx", host_cur_idx, 0);
    chk("R4 wrap chan", host_cur_chan, 0);

    // R7 / R8: sweep with distinct codes per channel
    for (int k = 0; k < 256; k++) look("R7 R8 sweep", k, 255 - k, k ^ 8'h5A);

    // R5: green-only rewrite of entries 10..12
    host_mask = 3'b010; set_idx(10);
    for (int i = 10; i < 13; i++)
      for (int c = 0; c < 3; c++) wr(pat(i, c, 7));
    pos("R5 pointer advanced");
    for (int i = 9; i < 14; i++) look("R5 masked entries", i, i, i);
    host_mask = 3'b101; set_idx(40);
    for (int c = 0; c < 3; c++) wr(pat(40, c, 9));
    look("R5 red blue only", 40, 40, 40);
    host_mask = 3'b111;

    // R6: power down blocks writes and pointer motion
    set_idx(50); wr(12'h111);
    lut_pwr_on = 0;
    for (int c = 0; c < 4; c++) wr(12'hABC);
    pos("R6 pointer held");
    look("R6 entry kept", 50, 50, 50);
    look("R6 next entry kept", 51, 51, 51);
    lut_pwr_on = 1;

    // R2: index write mid-entry, and collision with a data write
    set_idx(60); wr(12'h222);
    set_idx(20); pos("R2 mid entry reload");
    @(negedge clk); host_idx_wr = 1; host_idx = 8'd30; host_data_wr = 1; host_data = 12'hFFF;
    @(negedge clk); host_idx_wr = 0; host_data_wr = 0;
    m_idx = 30; m_ch = 0;
    pos("R2 collision");
    look("R2 collision no store", 30, 20, 20);

    // R4: wrap while writing entry 255
    set_idx(255);
    for (int c = 0; c < 3; c++) wr(pat(255, c, 3));
    pos("R4 wrap from 255");
    look("R4 entry 255", 255, 255, 255);
    look("R7 entry 0 intact", 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule